// File: doc/BRIEF.md
# Frame readback CRC scanning engine

The engine guards a frame-organised configuration memory against soft errors. While enabled, it reads the memory back one frame at a time through a simple read port. Each frame consists of a fixed number of 32-bit data beats followed by one stored check word. The engine recomputes a CRC-32 over the data beats of each frame and compares the result with that frame's check word. A mismatch produces a one-cycle error pulse together with the index of the failing frame.

Alongside the per-frame check, a second CRC runs across the data beats of every frame in the sweep. Once the final frame has been read, this column signature is compared with a reference value held outside the engine. A mismatch produces an end-of-sweep error pulse. The engine then wraps to frame zero and starts a new sweep, or returns to idle if the enable input has dropped. With a memory that never stalls, the engine takes in the 128 data bits of a frame in four consecutive cycles.

Top module: `frame_crc_scanner`

## Requirements
- R1: While rst_n is low, rd_req, frame_err, col_err and sweep_done are all 0.
- R2: While the engine is idle and en is low, rd_req stays 0.
- R3: A beat is transferred on a clock edge where rd_req and rd_valid are both 1. Within a frame, beats are requested with rd_beat counting 0 to DATA_BEATS, where beat DATA_BEATS is the check word. Frames are requested in ascending order, rd_frame counting 0 to NUM_FRAMES-1. While rd_req is 1 and rd_valid is 0, rd_frame and rd_beat hold.
- R4: The frame CRC uses polynomial 0x04C11DB7 with an all-ones seed, processes each 32-bit beat MSB first, and applies no final inversion or reflection. It is restarted at beat 0 of every frame and covers beats 0 to DATA_BEATS-1.
- R5: If a frame's CRC differs from its check word, frame_err is 1 for exactly one cycle, in the cycle after the check word is transferred. In that same cycle err_frame_addr shows the frame index, and err_frame_addr holds that value until the next frame error.
- R6: The column CRC is seeded at beat 0 of frame 0 and accumulates the data beats of all frames, excluding check words. In the cycle after the last frame's check word is transferred, col_err is 1 if the column CRC differs from col_ref.
- R7: sweep_done pulses for one cycle after the last frame's check word of every sweep, whether or not errors were found.
- R8: At the end of a sweep, the engine starts the next sweep at frame 0 immediately if en is 1, and goes idle otherwise. Dropping en in the middle of a sweep does not cut that sweep short.
- R9: With rd_valid held at 1, consecutive sweep_done pulses are NUM_FRAMES*(DATA_BEATS+1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Scan enable, sampled at idle and at sweep boundaries |
| col_ref | input | 32 | Stored column signature |
| rd_req | output | 1 | Read request, held until the beat is accepted |
| rd_frame | output | FRAME_W | Frame index of the requested beat |
| rd_beat | output | BEAT_W | Beat index within the frame (DATA_BEATS = check word) |
| rd_valid | input | 1 | Memory presents rd_data for the current request |
| rd_data | input | 32 | Read data beat |
| frame_err | output | 1 | One-cycle frame mismatch pulse |
| err_frame_addr | output | FRAME_W | Index of the most recent failing frame |
| col_err | output | 1 | One-cycle column mismatch pulse |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Faults in the sequencer appear at the read port on the very next transfer, as an out-of-order frame or beat index or an address that moves during a stall. A damaged frame accumulator shows up as a spurious or missing frame_err at that frame's check word, at most DATA_BEATS+1 transfers later. A damaged column accumulator stays hidden until the end of the sweep and then shows as a wrong col_err. The bench therefore compares the full set of failing frames and the column verdict at every sweep_done, checks every transfer address, and measures the spacing between sweeps.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int          WORD_W   = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;

  // One 32-bit beat folded into the CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc32_step(input logic [WORD_W-1:0] crc_in,
                                                   input logic [WORD_W-1:0] beat);
    logic [WORD_W-1:0] r;
    r = crc_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[WORD_W-1] ^ beat[i]) r = (r << 1) ^ CRC_POLY;
      else                       r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter  int NUM_FRAMES = 8,
  parameter  int DATA_BEATS = 4,
  localparam int FRAME_W    = $clog2(NUM_FRAMES),
  localparam int BEAT_W     = $clog2(DATA_BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               rd_valid,
  output logic               rd_req,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [BEAT_W-1:0]  rd_beat,
  output logic               take,
  output logic               on_check,
  output logic               first_beat,
  output logic               sweep_first,
  output logic               last_check
);

  localparam logic [FRAME_W-1:0] LAST_F  = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [BEAT_W-1:0]  CHECK_B = BEAT_W'(DATA_BEATS);

  scan_state_t        state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [BEAT_W-1:0]  beat_q,  beat_d;

  assign rd_req      = (state_q == ST_SCAN);
  assign rd_frame    = frame_q;
  assign rd_beat     = beat_q;
  assign take        = rd_req & rd_valid;
  assign on_check    = (beat_q == CHECK_B);
  assign first_beat  = (beat_q == '0);
  assign sweep_first = first_beat & (frame_q == '0);
  assign last_check  = take & on_check & (frame_q == LAST_F);

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        frame_d = '0;
        beat_d  = '0;
        if (en) state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (take) begin
          if (on_check) begin
            beat_d = '0;
            if (frame_q == LAST_F) begin
              frame_d = '0;
              state_d = en ? ST_SCAN : ST_IDLE;
            end else begin
              frame_d = frame_q + 1'b1;
            end
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      beat_q  <= beat_d;
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_frame) && $stable(rd_beat)));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_beat <= CHECK_B) && (rd_frame <= LAST_F)));

endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] crc
);

  logic [WORD_W-1:0] crc_q, crc_d;
  logic [WORD_W-1:0] base;

  assign base = restart ? CRC_SEED : crc_q;

  always_comb begin
    crc_d = crc_q;
    if (step_en) crc_d = crc32_step(base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/scan_report.sv
module scan_report
  import scan_pkg::*;
#(
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               check_take,
  input  logic               last_check,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic [WORD_W-1:0]  frame_crc,
  input  logic [WORD_W-1:0]  check_word,
  input  logic [WORD_W-1:0]  col_crc,
  input  logic [WORD_W-1:0]  col_ref,
  output logic               frame_err,
  output logic [FRAME_W-1:0] err_frame_addr,
  output logic               col_err,
  output logic               sweep_done
);

  logic               ferr_q, ferr_d;
  logic [FRAME_W-1:0] faddr_q, faddr_d;
  logic               cerr_q, cerr_d;
  logic               done_q, done_d;
  logic               frame_bad;

  assign frame_bad = (frame_crc != check_word);

  always_comb begin
    ferr_d  = check_take & frame_bad;
    faddr_d = faddr_q;
    if (check_take && frame_bad) faddr_d = frame_idx;
    done_d  = last_check;
    cerr_d  = last_check & (col_crc != col_ref);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q  <= 1'b0;
      faddr_q <= '0;
      cerr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ferr_q  <= ferr_d;
      faddr_q <= faddr_d;
      cerr_q  <= cerr_d;
      done_q  <= done_d;
    end
  end

  assign frame_err      = ferr_q;
  assign err_frame_addr = faddr_q;
  assign col_err        = cerr_q;
  assign sweep_done     = done_q;

  // R5
  frame_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R6
  col_err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_err |-> sweep_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

endmodule

// File: rtl/frame_crc_scanner.sv
module frame_crc_scanner
  import scan_pkg::*;
#(
  parameter  int NUM_FRAMES = 8,
  parameter  int DATA_BEATS = 4,
  localparam int FRAME_W    = $clog2(NUM_FRAMES),
  localparam int BEAT_W     = $clog2(DATA_BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [31:0]        col_ref,
  output logic               rd_req,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [BEAT_W-1:0]  rd_beat,
  input  logic               rd_valid,
  input  logic [31:0]        rd_data,
  output logic               frame_err,
  output logic [FRAME_W-1:0] err_frame_addr,
  output logic               col_err,
  output logic               sweep_done
);

  logic              take, on_check, first_beat, sweep_first, last_check;
  logic              data_take;
  logic [WORD_W-1:0] frame_crc, col_crc;

  scan_seq #(
    .NUM_FRAMES(NUM_FRAMES),
    .DATA_BEATS(DATA_BEATS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_frame   (rd_frame),
    .rd_beat    (rd_beat),
    .take       (take),
    .on_check   (on_check),
    .first_beat (first_beat),
    .sweep_first(sweep_first),
    .last_check (last_check)
  );

  assign data_take = take & ~on_check;

  crc_acc u_frame_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(data_take),
    .restart(first_beat),
    .din    (rd_data),
    .crc    (frame_crc)
  );

  crc_acc u_col_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(data_take),
    .restart(sweep_first),
    .din    (rd_data),
    .crc    (col_crc)
  );

  scan_report #(
    .FRAME_W(FRAME_W)
  ) u_report (
    .clk           (clk),
    .rst_n         (rst_n),
    .check_take    (take & on_check),
    .last_check    (last_check),
    .frame_idx     (rd_frame),
    .frame_crc     (frame_crc),
    .check_word    (rd_data),
    .col_crc       (col_crc),
    .col_ref       (col_ref),
    .frame_err     (frame_err),
    .err_frame_addr(err_frame_addr),
    .col_err       (col_err),
    .sweep_done    (sweep_done)
  );

  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rd_req) |=> !rd_req);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> $past(last_check));

endmodule

// File: tb/frame_crc_scanner_bench.sv
module frame_crc_scanner_bench;

  localparam int NF = 8;
  localparam int DB = 4;
  localparam int NB = DB + 1;
  localparam int FW = $clog2(NF);
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [31:0]   col_ref = '0;
  logic          rd_req;
  logic [FW-1:0] rd_frame;
  logic [BW-1:0] rd_beat;
  logic          rd_valid = 1'b0;
  logic [31:0]   rd_data;
  logic          frame_err;
  logic [FW-1:0] err_frame_addr;
  logic          col_err;
  logic          sweep_done;

  logic [31:0] mem [NF][NB];

  int checks = 0;
  int errors = 0;
  int ef = 0;
  int eb = 0;
  logic [NF-1:0] exp_mask;
  bit exp_col;

  always #10 clk = ~clk;

  always_comb begin
    rd_data = '0;
    if (int'(rd_beat) < NB && int'(rd_frame) < NF) rd_data = mem[rd_frame][rd_beat];
  end

  frame_crc_scanner #(.NUM_FRAMES(NF), .DATA_BEATS(DB)) u_frame_crc_scanner (
    .clk(clk), .rst_n(rst_n), .en(en), .col_ref(col_ref),
    .rd_req(rd_req), .rd_frame(rd_frame), .rd_beat(rd_beat),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .frame_err(frame_err), .err_frame_addr(err_frame_addr),
    .col_err(col_err), .sweep_done(sweep_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_beat(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic top = r[31];
      r = {r[30:0], 1'b0};
      if (top != d[i]) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] frame_sig(input int f);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < DB; b++) c = crc_beat(c, mem[f][b]);
    return c;
  endfunction

  function automatic logic [31:0] column_sig();
    logic [31:0] c = 32'hFFFFFFFF;
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < DB; b++) c = crc_beat(c, mem[f][b]);
    return c;
  endfunction

  // kind: 0 clean, 1 random corruption, 2 col_ref only wrong,
  //       3 data word of frame 0 and check word of last frame corrupted
  task automatic prepare(input int kind);
    logic [31:0] gold;
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < DB; b++) mem[f][b] = $urandom;
      mem[f][DB] = frame_sig(f);
    end
    gold = column_sig();
    col_ref = gold;
    if (kind == 1) begin
      int n = $urandom_range(0, 2);
      for (int k = 0; k < n; k++) begin
        int f = $urandom_range(0, NF - 1);
        int b = $urandom_range(0, DB);
        mem[f][b] = mem[f][b] ^ (32'h1 << $urandom_range(0, 31));
      end
      if ($urandom_range(0, 1) == 1) col_ref = gold ^ 32'h0000_0100;
    end else if (kind == 2) begin
      col_ref = gold ^ 32'h8000_0000;
    end else if (kind == 3) begin
      mem[0][1]      = mem[0][1] ^ 32'h0000_0001;
      mem[NF-1][DB]  = mem[NF-1][DB] ^ 32'h4000_0000;
    end
    for (int f = 0; f < NF; f++) exp_mask[f] = (frame_sig(f) != mem[f][DB]);
    exp_col = (column_sig() != col_ref);
  endtask

  task automatic run_sweep(input int stall_pct, input int drop_at, input int want_cycles);
    logic [NF-1:0] seen = '0;
    bit got_col = 0;
    bit done = 0;
    int cyc = 0;
    int last_bad = -1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (frame_err) begin
        seen[err_frame_addr] = 1'b1;
        last_bad = int'(err_frame_addr);
      end
      if (sweep_done) begin
        done = 1;
        got_col = col_err;
      end
      if (cyc == drop_at) en = 1'b0;
      rd_valid = ($urandom_range(0, 99) >= stall_pct);
      if (rd_req && rd_valid) begin
        // R3 transfer order check
        chk(int'(rd_frame) == ef && int'(rd_beat) == eb, "R3", "transfer frame/beat",
            {rd_frame, rd_beat}, (ef << BW) | eb);
        eb++;
        if (eb == NB) begin
          eb = 0;
          ef = (ef + 1) % NF;
        end
      end
    end
    // R5, R4 failing-frame set
    chk(seen == exp_mask, "R5", "failing frame mask", seen, exp_mask);
    // R6 column verdict
    chk(got_col == exp_col, "R6", "col_err", got_col, exp_col);
    if (last_bad >= 0)
      chk(int'(err_frame_addr) == last_bad, "R5", "err_frame_addr held", err_frame_addr, last_bad);
    // R9 sweep spacing
    if (want_cycles > 0)
      chk(cyc == want_cycles, "R9", "cycles between sweep_done", cyc, want_cycles);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < NB; b++) mem[f][b] = '0;
    repeat (3) begin
      @(negedge clk);
      // R1 reset state
      chk(!rd_req && !frame_err && !col_err && !sweep_done, "R1", "outputs in reset",
          {rd_req, frame_err, col_err, sweep_done}, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      // R2 idle while en low
      chk(!rd_req, "R2", "rd_req while idle", rd_req, 0);
    end

    // Clean sweeps without stalls, then spacing check (R9, R4)
    prepare(0);
    en = 1'b1;
    run_sweep(0, -1, 0);
    prepare(0);
    run_sweep(0, -1, NF * NB);
    // Column reference wrong, frames clean (R6)
    prepare(2);
    run_sweep(0, -1, NF * NB);
    // First-frame data and last-frame check word corrupted (R5, R6)
    prepare(3);
    run_sweep(20, -1, 0);

    // Random sweeps with stalls
    for (int s = 0; s < 24; s++) begin
      prepare(1);
      run_sweep((s % 3) * 20, -1, 0);
    end

    // R8: en dropped mid-sweep; the sweep completes, then idles
    prepare(1);
    run_sweep(10, 12, 0);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(!rd_req, "R8", "idle after sweep with en low", rd_req, 0);
    end
    // R8: restart from frame 0 after re-enable
    prepare(3);
    en = 1'b1;
    run_sweep(0, -1, 0);
    prepare(0);
    run_sweep(0, -1, NF * NB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule